// File: doc/BRIEF.md
# Fully Associative Micro-TLB

This block is a small first-level translation cache that sits in front of a larger shared main TLB. Each lookup presents a virtual page number. The number is compared against every stored entry at once. On a match, the physical page number and a pass-through attribute field come back in the same cycle. Separate copies of the block serve the instruction side and the data side. Both copies forward their misses to the one main TLB.

On a miss, the block raises a request toward the main TLB that carries the missing page number. It then holds that request steady and stalls further lookups until the reply arrives. The reply is written into a victim slot. The victim is chosen by one of two policies. Round-robin uses a pointer that moves only when an entry is written. Random uses a free-running linear feedback shift register. A flush input empties the whole buffer. If a flush lands while a miss is outstanding, that miss's reply is discarded.

Top module: `utlb`

## Requirements
- R1: After reset no entry is valid. `lk_ready` is 1, `mt_req_valid` is 0, and `lk_hit` is 0.
- R2: When `lk_valid` is high, the block is ready, and a valid entry holds `lk_vpn`, then `lk_hit` is 1 in the same cycle. In that cycle `lk_ppn` and `lk_attr` equal the page number and attribute that were installed for that entry. At most one entry ever matches.
- R3: A lookup with `lk_valid` high that misses while ready raises `mt_req_valid` in the next cycle, with `mt_req_vpn` equal to the missing page number. The request stays high, with the page number unchanged, until a cycle in which `mt_rsp_valid` is high. While the request is high, `lk_ready` is 0 and `lk_hit` is 0 whatever the lookup inputs are.
- R4: In a cycle where the request is high and `mt_rsp_valid` is 1, the reply is installed with the requested page number and the replied `mt_rsp_ppn` and `mt_rsp_attr`. The request drops in the next cycle, `lk_ready` returns to 1, and a later lookup of that page hits.
- R5: With `repl_random` = 0, fills go to slots 0, 1, 2 and so on up to slot 9 (10 entries by default), then wrap to slot 0. After reset or a flush the pointer is at slot 0. Hits, idle cycles and ignored replies do not move the pointer, so an eviction always removes the entry that was filled earliest among those still resident.
- R6: With `repl_random` = 1, the victim slot comes from the random register, always lies within 0 to 9, and the page that has just been filled hits on its next lookup.
- R7: A one-cycle `flush` pulse makes every entry invalid from the next cycle on. If the flush comes while a miss is outstanding, or in the same cycle as the reply, the handshake still completes but nothing is installed.
- R8: A reply (`mt_rsp_valid` = 1) that arrives while no request is outstanding has no effect. No entry changes, the pointer does not move, and no request is raised.
- R9: While `lk_valid` is 0, no request is raised, whatever value `lk_vpn` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries and cancel the pending fill |
| repl_random | input | 1 | Replacement policy: 0 round-robin, 1 random |
| lk_valid | input | 1 | Lookup strobe |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_ready | output | 1 | High when no miss is outstanding |
| lk_hit | output | 1 | Translation found this cycle |
| lk_ppn | output | 20 | Physical page number on a hit |
| lk_attr | output | 4 | Attribute field on a hit |
| mt_req_valid | output | 1 | Miss request to the main TLB |
| mt_req_vpn | output | 20 | Page number of the outstanding miss |
| mt_rsp_valid | input | 1 | Main TLB reply strobe |
| mt_rsp_ppn | input | 20 | Replied physical page number |
| mt_rsp_attr | input | 4 | Replied attribute field |

## Verification
The bench fills all ten slots and then keeps evicting. A pointer that advanced on hits, or failed to wrap, would remove the wrong page, and a later lookup would hit where a miss is due, or the reverse. A flush is sent while a miss is outstanding. A design that still installed the stale reply would then hit on a page that should be gone. Lookups are driven during the wait to catch a hit that leaks past the stall. Stray replies and idle cycles with a changing page number are applied, and the checks confirm that neither one installs an entry, moves the pointer, nor starts a request.

// File: rtl/utlb_pkg.sv
package utlb_pkg;

    typedef enum logic [0:0] {
        XL_IDLE = 1'b0,
        XL_WAIT = 1'b1
    } xl_state_e;

    localparam logic [7:0] LFSR_SEED = 8'h5A;

endpackage

// File: rtl/utlb_cam.sv
module utlb_cam #(
    parameter int N  = 10,
    parameter int VW = 20,
    parameter int PW = 20,
    parameter int AW = 4,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [VW-1:0] look_vpn,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [VW-1:0] wr_vpn,
    input  logic [PW-1:0] wr_ppn,
    input  logic [AW-1:0] wr_attr,
    output logic          hit,
    output logic [PW-1:0] hit_ppn,
    output logic [AW-1:0] hit_attr
);

    typedef struct packed {
        logic [N-1:0]          vld;
        logic [N-1:0][VW-1:0]  vpn;
        logic [N-1:0][PW-1:0]  ppn;
        logic [N-1:0][AW-1:0]  attr;
    } cam_t;

    cam_t s_d, s_q;
    logic [N-1:0] match;

    always_comb begin
        s_d = s_q;
        if (flush) begin
            s_d.vld = '0;
        end else if (wr_en) begin
            s_d.vld[wr_idx]  = 1'b1;
            s_d.vpn[wr_idx]  = wr_vpn;
            s_d.ppn[wr_idx]  = wr_ppn;
            s_d.attr[wr_idx] = wr_attr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = s_q.vld[g] && (s_q.vpn[g] == look_vpn);
    end

    always_comb begin
        hit_ppn  = '0;
        hit_attr = '0;
        for (int i = 0; i < N; i++) begin
            if (match[i]) begin
                hit_ppn  = hit_ppn  | s_q.ppn[i];
                hit_attr = hit_attr | s_q.attr[i];
            end
        end
    end

    assign hit = |match;

    // R2
    match_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    // R7
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !hit);

endmodule

// File: rtl/utlb_victim.sv
module utlb_victim #(
    parameter int N  = 10,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          mode_rand,
    input  logic          advance,
    output logic [IW-1:0] victim
);
    import utlb_pkg::*;

    localparam int LW = 8;

    typedef struct packed {
        logic [IW-1:0] rr;
        logic [LW-1:0] lfsr;
    } vic_t;

    vic_t s_d, s_q;
    logic          fb;
    logic [IW-1:0] rand_idx;

    assign fb = s_q.lfsr[7] ^ s_q.lfsr[5] ^ s_q.lfsr[4] ^ s_q.lfsr[3];

    always_comb begin
        s_d      = s_q;
        s_d.lfsr = {s_q.lfsr[LW-2:0], fb};
        if (flush) begin
            s_d.rr = '0;
        end else if (advance) begin
            s_d.rr = (s_q.rr == IW'(N - 1)) ? '0 : s_q.rr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{rr: '0, lfsr: LFSR_SEED};
        else        s_q <= s_d;
    end

    if ((1 << IW) == N) begin : g_pow2
        assign rand_idx = s_q.lfsr[IW-1:0];
    end else begin : g_mod
        assign rand_idx = IW'(s_q.lfsr % N);
    end

    assign victim = mode_rand ? rand_idx : s_q.rr;

    // R6
    victim_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(victim) < N);

    // R5
    rr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !flush) |=> $stable(s_q.rr));

endmodule

// File: rtl/utlb_ctrl.sv
module utlb_ctrl #(
    parameter int VW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          lk_valid,
    input  logic [VW-1:0] lk_vpn,
    input  logic          cam_hit,
    input  logic          rsp_valid,
    output logic          lk_ready,
    output logic          lk_hit,
    output logic          req_valid,
    output logic [VW-1:0] req_vpn,
    output logic          fill_en
);
    import utlb_pkg::*;

    typedef struct packed {
        xl_state_e     st;
        logic          drop;
        logic [VW-1:0] vpn;
    } ctl_t;

    ctl_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        fill_en = 1'b0;
        case (s_q.st)
            XL_IDLE: begin
                if (lk_valid && !cam_hit) begin
                    s_d.st   = XL_WAIT;
                    s_d.vpn  = lk_vpn;
                    s_d.drop = 1'b0;
                end
            end
            XL_WAIT: begin
                if (flush) s_d.drop = 1'b1;
                if (rsp_valid) begin
                    s_d.st   = XL_IDLE;
                    s_d.drop = 1'b0;
                    fill_en  = !s_q.drop && !flush;
                end
            end
            default: s_d.st = XL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{st: XL_IDLE, drop: 1'b0, vpn: '0};
        else        s_q <= s_d;
    end

    assign lk_ready  = (s_q.st == XL_IDLE);
    assign req_valid = (s_q.st == XL_WAIT);
    assign req_vpn   = s_q.vpn;
    assign lk_hit    = lk_valid && lk_ready && cam_hit;

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !rsp_valid) |=> (req_valid && $stable(req_vpn)));

    // R4
    req_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rsp_valid) |=> !req_valid);

    // R9
    no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && !lk_valid) |=> !req_valid);

endmodule

// File: rtl/utlb.sv
module utlb #(
    parameter int ENTRIES = 10,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20,
    parameter int ATTR_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              repl_random,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    output logic              lk_ready,
    output logic              lk_hit,
    output logic [PPN_W-1:0]  lk_ppn,
    output logic [ATTR_W-1:0] lk_attr,
    output logic              mt_req_valid,
    output logic [VPN_W-1:0]  mt_req_vpn,
    input  logic              mt_rsp_valid,
    input  logic [PPN_W-1:0]  mt_rsp_ppn,
    input  logic [ATTR_W-1:0] mt_rsp_attr
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic             cam_hit;
    logic             fill_en;
    logic [IDX_W-1:0] victim;

    utlb_cam #(
        .N (ENTRIES), .VW(VPN_W), .PW(PPN_W), .AW(ATTR_W), .IW(IDX_W)
    ) i_cam (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .look_vpn (lk_vpn),
        .wr_en    (fill_en),
        .wr_idx   (victim),
        .wr_vpn   (mt_req_vpn),
        .wr_ppn   (mt_rsp_ppn),
        .wr_attr  (mt_rsp_attr),
        .hit      (cam_hit),
        .hit_ppn  (lk_ppn),
        .hit_attr (lk_attr)
    );

    utlb_victim #(
        .N (ENTRIES), .IW(IDX_W)
    ) i_victim (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .mode_rand (repl_random),
        .advance   (fill_en),
        .victim    (victim)
    );

    utlb_ctrl #(
        .VW (VPN_W)
    ) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .lk_valid  (lk_valid),
        .lk_vpn    (lk_vpn),
        .cam_hit   (cam_hit),
        .rsp_valid (mt_rsp_valid),
        .lk_ready  (lk_ready),
        .lk_hit    (lk_hit),
        .req_valid (mt_req_valid),
        .req_vpn   (mt_req_vpn),
        .fill_en   (fill_en)
    );

    // R3
    wait_nohit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mt_req_valid |-> !lk_hit);

    // R2
    hit_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_ready && lk_valid));

endmodule

// File: tb/test_utlb.sv
module test_utlb;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 10;
    localparam int VW = 20;
    localparam int PW = 20;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush = 1'b0;
    logic          repl_random = 1'b0;
    logic          lk_valid = 1'b0;
    logic [VW-1:0] lk_vpn = '0;
    logic          lk_ready, lk_hit;
    logic [PW-1:0] lk_ppn;
    logic [AW-1:0] lk_attr;
    logic          mt_req_valid;
    logic [VW-1:0] mt_req_vpn;
    logic          mt_rsp_valid = 1'b0;
    logic [PW-1:0] mt_rsp_ppn = '0;
    logic [AW-1:0] mt_rsp_attr = '0;

    utlb i_utlb (
        .clk(clk), .rst_n(rst_n), .flush(flush), .repl_random(repl_random),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_ready(lk_ready),
        .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_attr(lk_attr),
        .mt_req_valid(mt_req_valid), .mt_req_vpn(mt_req_vpn),
        .mt_rsp_valid(mt_rsp_valid), .mt_rsp_ppn(mt_rsp_ppn),
        .mt_rsp_attr(mt_rsp_attr)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    logic [VW-1:0] mdl_vpn [N];
    bit            mdl_vld [N];
    int            mdl_rr = 0;
    bit            rand_mode = 0;

    function automatic logic [PW-1:0] ppn_of(input logic [VW-1:0] v);
        return v ^ 20'hA5A5A;
    endfunction

    function automatic logic [AW-1:0] attr_of(input logic [VW-1:0] v);
        return v[3:0] ^ 4'h9;
    endfunction

    function automatic int mdl_find(input logic [VW-1:0] v);
        for (int i = 0; i < N; i++)
            if (mdl_vld[i] && mdl_vpn[i] == v) return i;
        return -1;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic mdl_clear();
        for (int i = 0; i < N; i++) mdl_vld[i] = 0;
        mdl_rr = 0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        mdl_clear();
    endtask

    // called at the negedge after the missing lookup was registered
    task automatic serve(input logic [VW-1:0] v, input bit drop_flush);
        int dly;
        dly = 1 + int'(v % 3);
        #1;
        chk(mt_req_valid == 1'b1, "R3", "req raised", 32'(mt_req_valid), 1);
        chk(mt_req_vpn == v, "R3", "req vpn", 32'(mt_req_vpn), 32'(v));
        chk(lk_ready == 1'b0, "R3", "ready low", 32'(lk_ready), 0);
        for (int k = 0; k < dly; k++) begin
            if (k == 0) begin
                lk_valid = 1'b1;
                lk_vpn   = mdl_vld[0] ? mdl_vpn[0] : v;
                if (drop_flush) flush = 1'b1;
                #1;
                chk(lk_hit == 1'b0, "R3", "hit during stall", 32'(lk_hit), 0);
            end
            @(negedge clk);
            lk_valid = 1'b0;
            flush    = 1'b0;
            #1;
            chk(mt_req_valid && mt_req_vpn == v, "R3", "req held",
                32'(mt_req_vpn), 32'(v));
        end
        mt_rsp_valid = 1'b1;
        mt_rsp_ppn   = ppn_of(v);
        mt_rsp_attr  = attr_of(v);
        @(negedge clk);
        mt_rsp_valid = 1'b0;
        mt_rsp_ppn   = '0;
        #1;
        chk(mt_req_valid == 1'b0, "R4", "req dropped", 32'(mt_req_valid), 0);
        chk(lk_ready == 1'b1, "R4", "ready back", 32'(lk_ready), 1);
        if (drop_flush) begin
            mdl_clear();
        end else if (!rand_mode) begin
            mdl_vpn[mdl_rr] = v;
            mdl_vld[mdl_rr] = 1;
            mdl_rr = (mdl_rr + 1) % N;
        end
    endtask

    // force_exp: -1 use model, 0 expect miss, 1 expect hit
    task automatic access(input logic [VW-1:0] v, input int force_exp,
                          input string req, input bit drop_flush);
        bit exp_hit;
        @(negedge clk);
        lk_valid = 1'b1;
        lk_vpn   = v;
        #1;
        exp_hit = (force_exp < 0) ? (mdl_find(v) >= 0) : (force_exp == 1);
        chk(lk_hit == exp_hit, req, "hit flag", 32'(lk_hit), 32'(exp_hit));
        if (exp_hit) begin
            chk(lk_ppn == ppn_of(v), "R2", "ppn", 32'(lk_ppn), 32'(ppn_of(v)));
            chk(lk_attr == attr_of(v), "R2", "attr", 32'(lk_attr), 32'(attr_of(v)));
        end
        @(negedge clk);
        lk_valid = 1'b0;
        if (!exp_hit) serve(v, drop_flush);
    endtask

    task automatic t_reset();
        #1;
        chk(lk_ready == 1'b1, "R1", "ready", 32'(lk_ready), 1);
        chk(mt_req_valid == 1'b0, "R1", "req", 32'(mt_req_valid), 0);
        chk(lk_hit == 1'b0, "R1", "hit", 32'(lk_hit), 0);
        access(20'h00000, 0, "R1", 0);
    endtask

    task automatic t_round_robin();
        do_flush();
        for (int i = 0; i < N; i++) access(20'h100 + 20'(i), -1, "R5", 0);
        for (int i = 0; i < N; i++) access(20'h100 + 20'(i), 1, "R2", 0);
        access(20'h200, -1, "R5", 0);
        access(20'h100, -1, "R5", 0);
        access(20'h102, -1, "R5", 0);
        access(20'h101, -1, "R5", 0);
        access(20'h200, -1, "R4", 0);
    endtask

    task automatic t_idle_inputs();
        @(negedge clk);
        lk_valid = 1'b0;
        for (int i = 0; i < 3; i++) begin
            lk_vpn = 20'h333 + 20'(i);
            @(negedge clk);
            #1;
            chk(mt_req_valid == 1'b0, "R9", "no req while idle", 32'(mt_req_valid), 0);
        end
        mt_rsp_valid = 1'b1;
        mt_rsp_ppn   = 20'hFFFFF;
        mt_rsp_attr  = 4'hF;
        @(negedge clk);
        mt_rsp_valid = 1'b0;
        #1;
        chk(mt_req_valid == 1'b0 && lk_ready == 1'b1, "R8", "stray reply",
            32'(mt_req_valid), 0);
        for (int i = 0; i < N; i++)
            if (mdl_vld[i]) access(mdl_vpn[i], 1, "R8", 0);
        access(20'h555, -1, "R8", 0);
        access(20'h103, -1, "R8", 0);
    endtask

    task automatic t_flush();
        logic [VW-1:0] old;
        old = mdl_vpn[3];
        do_flush();
        access(old, 0, "R7", 0);
        access(20'h777, -1, "R7", 0);
        access(old, 1, "R7", 0);
        access(20'h444, 0, "R7", 1);
        access(20'h444, 0, "R7", 0);
        access(20'h444, 1, "R7", 0);
        access(old, 0, "R7", 0);
    endtask

    task automatic t_random();
        do_flush();
        rand_mode   = 1;
        repl_random = 1'b1;
        for (int i = 0; i < N + 5; i++) begin
            access(20'h9000 + 20'(i), 0, "R6", 0);
            access(20'h9000 + 20'(i), 1, "R6", 0);
        end
        repl_random = 1'b0;
        rand_mode   = 0;
        do_flush();
        access(20'h9001, 0, "R7", 0);
    endtask

    initial begin
        int cyc;
        cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
                $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
                $finish;
            end
        end
    end

    initial begin
        mdl_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_round_robin();
        t_idle_inputs();
        t_flush();
        t_random();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule